// File: doc/BRIEF.md
# Branch Target Landing-Pad Checker

This block sits beside the retire stage of a 64-bit processor and enforces landing-pad discipline for indirect branches. It tracks a 2-bit branch-type state that the previous retired instruction leaves behind. When the state is non-zero and the instruction now retiring comes from a guarded page, that instruction must be a landing pad that matches the kind of branch that reached it. If it is not, the block raises a one-cycle fault with a cause code.

Each retired instruction arrives with a valid strobe, its 32-bit word, a flag that marks its page as guarded, and a configuration bit. The configuration bit selects whether the pointer-signing prologue counts as a call-only pad or as a pad for any branch. The check always uses the state as it was before the instruction. Only then is the state updated: every executed instruction clears it, and a taken register branch or register call loads a new value. Landing pads on unguarded pages are plain no-ops.

Top module: `lpad_guard`

## Requirements
- R1: A synchronous active-high `rst` clears `btype_q` to 00 and `fault_pulse` to 0, whatever state the block was in.
- R2: After a valid instruction that does not fault, `btype_q` takes these values. A register jump (word 0xD61F0000 with the register number in bits [9:5]) gives 01 from an unguarded page or through register 16 or 17, and 11 from a guarded page through any other register. A register call (0xD63F0000 with the register in [9:5]) gives 10. Every other instruction, including a return, gives 00.
- R3: No fault is raised when the state is 00, or when `ret_guarded` is low for the retiring instruction.
- R4: The landing pads are hint words 0xD503201F | (imm << 5) with imm 32 (plain), 34 (call), 36 (jump) or 38 (both). Pad 38 accepts every state. Pad 34 accepts 01 and 10. Pad 36 accepts 01 and 11.
- R5: A landing pad whose variant does not accept the current non-zero state faults with cause 10. The plain pad (imm 32) faults in every non-zero state.
- R6: The signing prologue (hint imm 25) passes in every state when `pac_as_call` is 0. When `pac_as_call` is 1 it faults with cause 11 in state 11 and passes in states 01 and 10.
- R7: Breakpoint words (0xD4200000) and halt words (0xD4400000) pass in any state, whatever their 16-bit immediate in bits [20:5].
- R8: On a guarded page with non-zero state, any other instruction faults with cause 01. This includes other hint immediates and branch words whose low bits are not zero.
- R9: `fault_pulse` rises in the cycle after the offending instruction and lasts one cycle per offending instruction. `fault_cause` is 00 whenever `fault_pulse` is low. After a fault `btype_q` is 00, even if the faulting word was a branch.
- R10: While `ret_valid` is low, `btype_q` holds its value and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ret_valid | input | 1 | A retired instruction is present this cycle |
| ret_insn | input | 32 | Word of the retiring instruction |
| ret_guarded | input | 1 | The retiring instruction's page is guarded |
| pac_as_call | input | 1 | 1: signing prologue is a call-only pad; 0: it accepts any branch |
| btype_q | output | 2 | Current branch-type state |
| fault_pulse | output | 1 | One-cycle landing-pad fault |
| fault_cause | output | 2 | 01 non-pad, 10 wrong pad variant, 11 prologue refused, 00 no fault |

## Verification
The assertions assume that `ret_guarded` and `pac_as_call` are valid and stable in every cycle where `ret_valid` is high. They also assume that reset is held for at least one clock before the first instruction arrives. The bench changes inputs only on the falling edge and holds reset for three cycles. It drives every branch source and target combination from the acceptance rules, including pads reached from an unguarded page, idle cycles that carry stray words, and a branch that faults itself.

// File: rtl/lpad_pkg.sv
package lpad_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned REG_W    = 5;
  localparam int unsigned HIMM_W   = 7;

  localparam logic [WORD_W-1:0] HINT_MASK = 32'hFFFFF01F;
  localparam logic [WORD_W-1:0] HINT_BASE = 32'hD503201F;
  localparam logic [WORD_W-1:0] BRX_MASK  = 32'hFFFFFC1F;
  localparam logic [WORD_W-1:0] JMP_BASE  = 32'hD61F0000;
  localparam logic [WORD_W-1:0] CALL_BASE = 32'hD63F0000;
  localparam logic [WORD_W-1:0] EXC_MASK  = 32'hFFE0001F;
  localparam logic [WORD_W-1:0] BRK_BASE  = 32'hD4200000;
  localparam logic [WORD_W-1:0] HLT_BASE  = 32'hD4400000;

  localparam logic [HIMM_W-1:0] PAD_PLAIN = 7'd32;
  localparam logic [HIMM_W-1:0] PAD_CALL  = 7'd34;
  localparam logic [HIMM_W-1:0] PAD_JUMP  = 7'd36;
  localparam logic [HIMM_W-1:0] PAD_BOTH  = 7'd38;
  localparam logic [HIMM_W-1:0] SIGN_PRO  = 7'd25;

  typedef enum logic [1:0] {
    BT_NONE    = 2'b00,
    BT_JMP_IP  = 2'b01,
    BT_CALL    = 2'b10,
    BT_JMP_ANY = 2'b11
  } btype_e;

  typedef enum logic [1:0] {
    FC_NONE    = 2'b00,
    FC_NOT_PAD = 2'b01,
    FC_BAD_PAD = 2'b10,
    FC_PAC_NO  = 2'b11
  } cause_e;

  typedef struct packed {
    logic              is_jmp;
    logic              is_call;
    logic              is_pad;
    logic              is_pac;
    logic              is_exc;
    logic [HIMM_W-1:0] himm;
    logic [REG_W-1:0]  rn;
  } insn_class_t;

  function automatic logic match(input logic [WORD_W-1:0] w,
                                 input logic [WORD_W-1:0] mask,
                                 input logic [WORD_W-1:0] base);
    return (w & mask) == base;
  endfunction

  // Acceptance of a pad variant for a given branch-type state
  function automatic logic pad_accepts(input logic [HIMM_W-1:0] imm,
                                       input btype_e st);
    logic ok;
    unique case (imm)
      PAD_PLAIN: ok = (st == BT_NONE);
      PAD_CALL:  ok = (st != BT_JMP_ANY);
      PAD_JUMP:  ok = (st != BT_CALL);
      PAD_BOTH:  ok = 1'b1;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/lpad_decode.sv
module lpad_decode
  import lpad_pkg::*;
(
  input  logic [WORD_W-1:0] insn,
  output insn_class_t       cls
);

  logic              hint_w;
  logic [HIMM_W-1:0] imm;

  assign hint_w = match(insn, HINT_MASK, HINT_BASE);
  assign imm    = insn[11:5];

  always_comb begin
    cls         = '0;
    cls.rn      = insn[9:5];
    cls.himm    = imm;
    cls.is_jmp  = match(insn, BRX_MASK, JMP_BASE);
    cls.is_call = match(insn, BRX_MASK, CALL_BASE);
    cls.is_pad  = hint_w && ((imm == PAD_PLAIN) || (imm == PAD_CALL) ||
                             (imm == PAD_JUMP)  || (imm == PAD_BOTH));
    cls.is_pac  = hint_w && (imm == SIGN_PRO);
    cls.is_exc  = match(insn, EXC_MASK, BRK_BASE) || match(insn, EXC_MASK, HLT_BASE);
  end

endmodule

// File: rtl/lpad_judge.sv
module lpad_judge
  import lpad_pkg::*;
#(
  parameter int unsigned IP0_REG = 16,
  parameter int unsigned IP1_REG = 17
) (
  input  logic        valid,
  input  logic        guarded,
  input  logic        pac_as_call,
  input  insn_class_t cls,
  input  btype_e      cur,
  output logic        check_en,
  output logic        fault_now,
  output cause_e      cause_now,
  output btype_e      nxt
);

  localparam logic [REG_W-1:0] IP0 = REG_W'(IP0_REG);
  localparam logic [REG_W-1:0] IP1 = REG_W'(IP1_REG);

  logic via_ip;

  assign check_en = valid && guarded && (cur != BT_NONE);
  assign via_ip   = (cls.rn == IP0) || (cls.rn == IP1);

  always_comb begin
    cause_now = FC_NONE;
    if (check_en) begin
      if (cls.is_pad) begin
        if (!pad_accepts(cls.himm, cur)) cause_now = FC_BAD_PAD;
      end else if (cls.is_pac) begin
        if (pac_as_call && (cur == BT_JMP_ANY)) cause_now = FC_PAC_NO;
      end else if (!cls.is_exc) begin
        cause_now = FC_NOT_PAD;
      end
    end
  end

  assign fault_now = (cause_now != FC_NONE);

  always_comb begin
    if (!valid)                 nxt = cur;
    else if (fault_now)         nxt = BT_NONE;
    else if (cls.is_jmp)        nxt = (!guarded || via_ip) ? BT_JMP_IP : BT_JMP_ANY;
    else if (cls.is_call)       nxt = BT_CALL;
    else                        nxt = BT_NONE;
  end

endmodule

// File: rtl/lpad_state.sv
module lpad_state
  import lpad_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  btype_e nxt,
  input  logic   fault_now,
  input  cause_e cause_now,
  output btype_e state_q,
  output logic   fault_q,
  output cause_e cause_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BT_NONE;
      fault_q <= 1'b0;
      cause_q <= FC_NONE;
    end else begin
      state_q <= nxt;
      fault_q <= fault_now;
      cause_q <= cause_now;
    end
  end

endmodule

// File: rtl/lpad_guard.sv
module lpad_guard
  import lpad_pkg::*;
#(
  parameter int unsigned IP0_REG = 16,
  parameter int unsigned IP1_REG = 17
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ret_valid,
  input  logic [31:0] ret_insn,
  input  logic        ret_guarded,
  input  logic        pac_as_call,
  output logic [1:0]  btype_q,
  output logic        fault_pulse,
  output logic [1:0]  fault_cause
);

  insn_class_t cls;
  logic        check_en;
  logic        fault_now;
  cause_e      cause_now;
  btype_e      nxt;
  btype_e      state_q;
  cause_e      cause_q;

  lpad_decode u_decode (
    .insn (ret_insn),
    .cls  (cls)
  );

  lpad_judge #(
    .IP0_REG (IP0_REG),
    .IP1_REG (IP1_REG)
  ) u_judge (
    .valid       (ret_valid),
    .guarded     (ret_guarded),
    .pac_as_call (pac_as_call),
    .cls         (cls),
    .cur         (state_q),
    .check_en    (check_en),
    .fault_now   (fault_now),
    .cause_now   (cause_now),
    .nxt         (nxt)
  );

  lpad_state u_state (
    .clk       (clk),
    .rst       (rst),
    .nxt       (nxt),
    .fault_now (fault_now),
    .cause_now (cause_now),
    .state_q   (state_q),
    .fault_q   (fault_pulse),
    .cause_q   (cause_q)
  );

  assign btype_q     = state_q;
  assign fault_cause = cause_q;

  AST_CALL_LOADS_10: assert property (@(posedge clk) disable iff (rst)
    ret_valid && cls.is_call && !fault_now |=> btype_q == 2'b10); // R2
  AST_UNGUARDED_SILENT: assert property (@(posedge clk) disable iff (rst)
    ret_valid && !ret_guarded |=> !fault_pulse); // R3
  AST_IDLE_STATE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !check_en |=> !fault_pulse); // R3
  AST_EXC_PASSES: assert property (@(posedge clk) disable iff (rst)
    ret_valid && cls.is_exc |=> !fault_pulse); // R7
  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    fault_pulse |-> btype_q == 2'b00); // R9
  AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !fault_pulse |-> fault_cause == 2'b00); // R9
  AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !ret_valid |=> $stable(btype_q) && !fault_pulse); // R10

endmodule

// File: tb/lpad_guard_bench.sv
module lpad_guard_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        v   = 1'b0;
  logic [31:0] w   = '0;
  logic        g   = 1'b0;
  logic        cfg = 1'b0;
  logic [1:0]  st;
  logic        fp;
  logic [1:0]  fc;

  int          n_run  = 0;
  int          n_fail = 0;
  logic [1:0]  m_state = 2'b00;
  logic [4:0]  exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  lpad_guard u_lpad_guard (
    .clk (clk), .rst (rst), .ret_valid (v), .ret_insn (w),
    .ret_guarded (g), .pac_as_call (cfg),
    .btype_q (st), .fault_pulse (fp), .fault_cause (fc)
  );

  function automatic logic [31:0] hint_w(input int imm);
    return 32'hD503201F | (32'(imm) << 5);
  endfunction
  function automatic logic [31:0] jmp_w(input int r);
    return 32'hD61F0000 | (32'(r) << 5);
  endfunction
  function automatic logic [31:0] call_w(input int r);
    return 32'hD63F0000 | (32'(r) << 5);
  endfunction

  localparam logic [31:0] ADD_W = 32'h8B020020;
  localparam logic [31:0] RET_W = 32'hD65F03C0;

  // Driver: applies one retire slot and queues the expected outcome
  task automatic issue(input logic vv, input logic [31:0] ww, input logic gg,
                       input logic cc, input string tag);
    logic [1:0] c;
    logic [1:0] ns;
    c  = 2'b00;
    ns = m_state;
    if (vv) begin
      if (gg && m_state != 2'b00) begin
        if (ww == hint_w(32))                      c = 2'b10;
        else if (ww == hint_w(34))                 c = (m_state == 2'b11) ? 2'b10 : 2'b00;
        else if (ww == hint_w(36))                 c = (m_state == 2'b10) ? 2'b10 : 2'b00;
        else if (ww == hint_w(38))                 c = 2'b00;
        else if (ww == hint_w(25))                 c = (cc && m_state == 2'b11) ? 2'b11 : 2'b00;
        else if ((ww[31:21] == 11'h6A1 || ww[31:21] == 11'h6A2) && ww[4:0] == 5'd0)
                                                   c = 2'b00;
        else                                       c = 2'b01;
      end
      if (c != 2'b00)
        ns = 2'b00;
      else if (ww[31:10] == 22'h3587C0 && ww[4:0] == 5'd0)
        ns = (!gg || ww[9:5] == 5'd16 || ww[9:5] == 5'd17) ? 2'b01 : 2'b11;
      else if (ww[31:10] == 22'h358FC0 && ww[4:0] == 5'd0)
        ns = 2'b10;
      else
        ns = 2'b00;
    end
    m_state = ns;
    @(negedge clk);
    v = vv; w = ww; g = gg; cfg = cc;
    exp_q.push_back({ns, (c != 2'b00), c});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares each registered result just after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if ({st, fp, fc} !== e) begin
        n_fail++;
        $display("FAIL %s: state/fault/cause got %b/%b/%b expected %b/%b/%b",
                 t, st, fp, fc, e[4:3], e[2], e[1:0]);
      end
    end
  end

  task automatic direct_check(input logic ok, input string msg);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: state %b fault %b expected 00 0", msg, st, fp);
    end
  endtask

  logic done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got not-done expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    direct_check(st == 2'b00 && fp == 1'b0, "R1 reset state");
    rst = 1'b0;

    issue(1, ADD_W,      1, 0, "R3 ordinary in state 00");
    issue(1, jmp_w(0),   1, 0, "R2 jump guarded x0 -> 11");
    issue(1, hint_w(36), 1, 0, "R4 jump pad accepts 11");
    issue(1, jmp_w(16),  1, 0, "R2 jump via x16 -> 01");
    issue(1, hint_w(34), 1, 0, "R4 call pad accepts 01");
    issue(1, jmp_w(3),   0, 0, "R2 jump from unguarded -> 01");
    issue(1, ADD_W,      1, 0, "R8 non-pad faults cause 01");
    issue(1, call_w(5),  1, 0, "R2 call -> 10");
    issue(1, hint_w(36), 1, 0, "R5 jump pad refuses 10");
    issue(1, jmp_w(1),   1, 0, "R2 jump guarded x1 -> 11");
    issue(1, hint_w(34), 1, 0, "R5 call pad refuses 11");
    issue(1, jmp_w(17),  1, 0, "R2 jump via x17 -> 01");
    issue(1, hint_w(32), 1, 0, "R5 plain pad refuses 01");
    issue(1, call_w(30), 1, 0, "R2 call -> 10");
    issue(1, hint_w(38), 1, 0, "R4 both pad accepts 10");
    issue(1, jmp_w(16),  1, 0, "R2 jump via x16 -> 01");
    issue(1, hint_w(38), 1, 0, "R4 both pad accepts 01");
    issue(1, jmp_w(9),   1, 1, "R2 jump guarded -> 11");
    issue(1, hint_w(25), 1, 1, "R6 prologue as call refused in 11");
    issue(1, jmp_w(9),   1, 0, "R2 jump guarded -> 11");
    issue(1, hint_w(25), 1, 0, "R6 prologue as both passes 11");
    issue(1, call_w(2),  1, 1, "R2 call -> 10");
    issue(1, hint_w(25), 1, 1, "R6 prologue as call passes 10");
    issue(1, jmp_w(16),  1, 1, "R2 jump via x16 -> 01");
    issue(1, hint_w(25), 1, 1, "R6 prologue as call passes 01");
    issue(1, jmp_w(2),   1, 0, "R2 jump guarded -> 11");
    issue(1, 32'hD4224680, 1, 0, "R7 breakpoint passes");
    issue(1, call_w(4),  1, 0, "R2 call -> 10");
    issue(1, 32'hD45FFFE0, 1, 0, "R7 halt passes");
    issue(1, jmp_w(2),   1, 0, "R2 jump guarded -> 11");
    issue(1, ADD_W,      0, 0, "R3 unguarded target no check");
    issue(1, call_w(6),  1, 0, "R2 call -> 10");
    issue(1, hint_w(32), 0, 0, "R3 plain pad on unguarded page is nop");
    issue(1, jmp_w(7),   1, 0, "R2 jump guarded -> 11");
    issue(0, hint_w(32), 1, 0, "R10 invalid slot holds state");
    issue(0, jmp_w(16),  1, 0, "R10 invalid jump word ignored");
    issue(1, hint_w(36), 1, 0, "R10 state kept through idle, pad passes");
    issue(1, jmp_w(8),   1, 0, "R2 jump guarded -> 11");
    issue(1, jmp_w(16),  1, 0, "R9 faulting jump leaves state 00");
    issue(1, ADD_W,      1, 0, "R9 single pulse, state 00 no check");
    issue(1, call_w(3),  1, 0, "R2 call -> 10");
    issue(1, hint_w(33), 1, 0, "R8 near-pad hint faults cause 01");
    issue(1, jmp_w(8),   1, 0, "R2 jump guarded -> 11");
    issue(1, jmp_w(8) | 32'h1, 1, 0, "R8 jump with low bits set is non-pad");
    issue(1, call_w(3),  1, 0, "R2 call -> 10");
    issue(1, RET_W,      1, 0, "R8 return in state 10 faults");
    issue(1, RET_W,      1, 0, "R2 return gives 00");
    issue(1, call_w(3),  1, 0, "R2 call -> 10");
    issue(1, hint_w(34), 1, 0, "R4 call pad accepts 10");
    issue(1, jmp_w(5),   1, 0, "R2 jump guarded -> 11");
    issue(0, ADD_W,      1, 0, "R10 idle");

    @(negedge clk);
    v = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);

    // reset while state is non-zero
    rst = 1'b1;
    @(negedge clk);
    direct_check(st == 2'b00 && fp == 1'b0, "R1 reset clears state 11");
    rst = 1'b0;
    m_state = 2'b00;
    issue(1, hint_w(32), 1, 0, "R1 plain pad after reset passes");
    issue(0, ADD_W,      1, 0, "R10 idle tail");
    @(negedge clk);
    v = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule